// File: doc/BRIEF.md
# Page-Mode Word-Wide Memory Port

This block is a clock-sampled model of a word-wide memory that behaves like an asynchronous static RAM. It has active-low strobes for chip enable, write enable, output enable and the upper and lower byte lanes. It takes a 17-bit word address and presents a 16-bit data path as a separate write bus, read bus and per-lane output enable. Every strobe is sampled on the rising clock edge. Access, page and precharge times are given in clock cycles through parameters.

An access starts when chip enable goes low and the precharge interval is over. At that point the whole address is captured and the random access latency starts. While chip enable stays low, a change of the two column bits alone opens another word of the same four-word row after a much shorter page latency. A change of the row bits closes the row, runs a precharge and starts a new random access at the new address. Writes can be framed either by chip enable or by write enable. Each byte lane is masked on its own. An eight-bit sector-protect input silently discards writes to protected eighths of the address space.

The array is a register file whose depth is a parameter, so a small instance can stand in for the full memory.

Top module: `pgsram_port`

## Requirements
- R1: After reset both lanes are undriven, the FSM is idle and every stored word reads as zero.
- R2: The access starts on the first rising clock edge at which the chip enable is sampled low with no precharge running. The full address is captured at that edge. Read data is driven T_RAND edges later.
- R3: Once chip enable is sampled high, or a row change is seen, no new access starts until T_PRE edges have passed.
- R4: With chip enable low and the row bits (address 16:2) unchanged, a change of address bits 1:0 is served after T_PAGE edges, and the bus is undriven until then.
- R5: If write enable is low at the edge where the access starts, the bus is never driven for that access, whatever the output enable does.
- R6: In an access that started as a read, the drive stops while write enable is low and resumes once it is high again.
- R7: A write commits at the first edge where write enable or chip enable is sampled high after write enable was low. It stores the data and byte selects that were sampled one edge earlier, at the current column. Each new write-enable pulse with a new column writes again.
- R8: Lane 1 (bits 15:8) is gated by the upper select and lane 0 (bits 7:0) by the lower select, both active low. A deselected lane keeps its stored byte on a write and reads as undriven, with zero data, on a read.
- R9: Bit k of the protect input guards the sector whose address bits 16:14 equal k. Writes there change nothing. Reads there are unaffected.
- R10: A row change while chip enable stays low gives valid data at the new address T_PRE + T_RAND edges after the change is sampled.
- R11: A lane is driven only when output enable is low, its select is low and the access latency has elapsed. Asserting output enable early drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| ub_ni | input | 1 | Upper lane select, active low |
| lb_ni | input | 1 | Lower lane select, active low |
| addr_i | input | ADDR_W | Word address; bits 1:0 are the column |
| wdata_i | input | 16 | Write data |
| protect_i | input | 2**SECT_W | Per-sector write block |
| rdata_o | output | 16 | Read data; zero on undriven lanes |
| drive_o | output | 2 | Per-lane output enable |

## Verification
A write commit and the opening of a precharge can land on the same edge. This happens when chip enable is raised while write enable is still low: the store must use the address still latched while the FSM leaves the row. It also happens in a page write, where the column for the next write and the commit of the previous pulse fall on neighbouring edges. The bench drives both orderings: chip-enable-framed writes across all sixteen words with varied lane masks, and write-enable-framed page writes in a protected and an unprotected row. It then reads every word back through page accesses and compares the results with a bench-side model.

// File: rtl/pgsram_pkg.sv
package pgsram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACC  = 2'd2,
    ST_OPEN = 2'd3
  } st_e;
endpackage

// File: rtl/pgsram_timing.sv
module pgsram_timing
  import pgsram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int T_RAND = 6,
  parameter int T_PAGE = 2,
  parameter int T_PRE  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic              open_o,
  output logic              active_o,
  output logic              wr_cyc_o,
  output logic              commit_o
);
  localparam int MAX_T = (T_RAND > T_PRE) ? ((T_RAND > T_PAGE) ? T_RAND : T_PAGE)
                                          : ((T_PRE > T_PAGE) ? T_PRE : T_PAGE);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] RAND_LD = CNT_W'(T_RAND - 1);
  localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(T_PAGE - 1);
  localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(T_PRE - 1);

  st_e               st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              wr_q, wr_n;
  logic              we_lo_q;
  logic              start;
  logic              row_chg, col_chg;

  assign row_chg = addr_i[ADDR_W-1:2] != addr_q[ADDR_W-1:2];
  assign col_chg = addr_i[1:0] != addr_q[1:0];

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    wr_n   = wr_q;
    start  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!ce_ni) start = 1'b1;
      ST_PRE: begin
        if (cnt_q == '0) begin
          if (!ce_ni) start = 1'b1;
          else        st_n  = ST_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: begin
        if (ce_ni || row_chg) begin
          st_n  = ST_PRE;
          cnt_n = PRE_LD;
        end else if (col_chg) begin
          addr_n[1:0] = addr_i[1:0];
          st_n        = ST_ACC;
          cnt_n       = (st_q == ST_OPEN || cnt_q <= PAGE_LD) ? PAGE_LD : cnt_q - 1'b1;
        end else if (st_q == ST_ACC) begin
          if (cnt_q == '0) st_n = ST_OPEN;
          else             cnt_n = cnt_q - 1'b1;
        end
      end
    endcase
    if (start) begin
      st_n   = ST_ACC;
      cnt_n  = RAND_LD;
      addr_n = addr_i;
      wr_n   = ~we_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      we_lo_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      addr_q  <= addr_n;
      wr_q    <= wr_n;
      we_lo_q <= ~we_ni;
    end
  end

  assign active_o   = (st_q == ST_ACC) || (st_q == ST_OPEN);
  assign open_o     = st_q == ST_OPEN;
  assign wr_cyc_o   = wr_q;
  assign lat_addr_o = addr_q;
  // first rising edge of either strobe ends the write
  assign commit_o   = active_o && we_lo_q && (we_ni || ce_ni);

  // independent gap counter used only by the precharge check
  logic [CNT_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  gap_q <= CNT_W'(T_PRE);
    else if (st_n == ST_PRE && st_q != ST_PRE)    gap_q <= '0;
    else if (gap_q < CNT_W'(T_PRE))               gap_q <= gap_q + 1'b1;
  end

  p_pre_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> gap_q >= PRE_LD);

  p_open_after_acc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OPEN && $past(st_q) != ST_OPEN) |-> $past(st_q) == ST_ACC);
endmodule

// File: rtl/pgsram_array.sv
module pgsram_array #(
  parameter int ADDR_W  = 17,
  parameter int DEPTH_W = 8,
  parameter int LANES   = 2,
  parameter int SECT_W  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2**SECT_W-1:0]  protect_i,
  input  logic [LANES-1:0]      be_i,
  input  logic [8*LANES-1:0]    wdata_i,
  output logic [8*LANES-1:0]    rdata_o
);
  localparam int DEPTH  = 1 << DEPTH_W;
  localparam int DATA_W = 8 * LANES;

  logic [DATA_W-1:0]  mem_q [DEPTH];
  logic [DEPTH_W-1:0] idx;
  logic [SECT_W-1:0]  sector;
  logic               blocked;
  logic               unused_addr;

  assign idx         = addr_i[DEPTH_W-1:0];
  assign sector      = addr_i[ADDR_W-1 -: SECT_W];
  assign blocked     = protect_i[sector];
  assign unused_addr = ^addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else if (we_i && !blocked) begin
      for (int l = 0; l < LANES; l++)
        if (be_i[l]) mem_q[idx][8*l +: 8] <= wdata_i[8*l +: 8];
    end
  end

  assign rdata_o = mem_q[idx];

  p_protect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && blocked) |=> mem_q[$past(idx)] == $past(mem_q[idx]));

  for (genvar l = 0; l < LANES; l++) begin : g_mask_chk
    p_lane_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !be_i[l]) |=> mem_q[$past(idx)][8*l +: 8] == $past(mem_q[idx][8*l +: 8]));
  end
endmodule

// File: rtl/pgsram_bus.sv
module pgsram_bus #(
  parameter int LANES = 2
) (
  input  logic               open_i,
  input  logic               wr_cyc_i,
  input  logic               oe_ni,
  input  logic               we_ni,
  input  logic [LANES-1:0]   sel_i,
  input  logic [8*LANES-1:0] word_i,
  output logic [8*LANES-1:0] rdata_o,
  output logic [LANES-1:0]   drive_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign drive_o[l]         = open_i & ~wr_cyc_i & ~oe_ni & we_ni & sel_i[l];
    assign rdata_o[8*l +: 8]  = drive_o[l] ? word_i[8*l +: 8] : 8'h00;
  end
endmodule

// File: rtl/pgsram_port.sv
module pgsram_port #(
  parameter int ADDR_W  = 17,
  parameter int DEPTH_W = 8,
  parameter int SECT_W  = 3,
  parameter int T_RAND  = 6,
  parameter int T_PAGE  = 2,
  parameter int T_PRE   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic                 ub_ni,
  input  logic                 lb_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [15:0]          wdata_i,
  input  logic [2**SECT_W-1:0] protect_i,
  output logic [15:0]          rdata_o,
  output logic [1:0]           drive_o
);
  localparam int LANES = 2;

  logic [ADDR_W-1:0] lat_addr;
  logic              open, active, wr_cyc, commit;
  logic [15:0]       wdata_q, word;
  logic [LANES-1:0]  be_q, sel;

  assign sel = {~ub_ni, ~lb_ni};

  // data and lane selects are taken one sample before the closing edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      wdata_q <= wdata_i;
      be_q    <= sel;
    end
  end

  pgsram_timing #(
    .ADDR_W(ADDR_W), .T_RAND(T_RAND), .T_PAGE(T_PAGE), .T_PRE(T_PRE)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .addr_i(addr_i),
    .lat_addr_o(lat_addr), .open_o(open), .active_o(active), .wr_cyc_o(wr_cyc),
    .commit_o(commit)
  );

  pgsram_array #(
    .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .LANES(LANES), .SECT_W(SECT_W)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(commit), .addr_i(lat_addr),
    .protect_i(protect_i), .be_i(be_q), .wdata_i(wdata_q), .rdata_o(word)
  );

  pgsram_bus #(.LANES(LANES)) u_bus (
    .open_i(open), .wr_cyc_i(wr_cyc), .oe_ni(oe_ni), .we_ni(we_ni), .sel_i(sel),
    .word_i(word), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  p_wrcyc_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cyc && active) |-> drive_o == '0);
endmodule

// File: tb/pgsram_port_test.sv
module pgsram_port_test;
  localparam int TR = 5;
  localparam int TP = 2;
  localparam int TC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b0, lb_n = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  prot = 8'b0000_0100;
  logic [15:0] rdata;
  logic [1:0]  drive;
  logic [15:0] mem_m [16];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pgsram_port #(.DEPTH_W(4), .T_RAND(TR), .T_PAGE(TP), .T_PRE(TC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .ub_ni(ub_n), .lb_ni(lb_n), .addr_i(addr), .wdata_i(wdata), .protect_i(prot),
    .rdata_o(rdata), .drive_o(drive)
  );

  function automatic logic [16:0] addr_of(input int i);
    logic [3:0] v;
    v = 4'(i);
    return {1'b0, v[3:2], 10'h000, v};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input int i, input logic [15:0] d, input logic ubm, input logic lbm);
    logic [16:0] a;
    a = addr_of(i);
    if (!prot[a[16:14]]) begin
      if (!ubm) mem_m[i][15:8] = d[15:8];
      if (!lbm) mem_m[i][7:0]  = d[7:0];
    end
  endtask

  task automatic close_row();
    ce_n = 1'b1;
    wait_n(TC + 1);
  endtask

  // R5 R7 R8 R9: chip-enable framed write, closed by chip enable rising
  task automatic wr_ce(input int i, input logic [15:0] d, input logic ubm, input logic lbm);
    addr = addr_of(i); wdata = d; ub_n = ubm; lb_n = lbm; we_n = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
    wait_n(TR + 1);
    chk("R5 no drive in write cycle", {30'd0, drive}, 32'd0);
    ce_n = 1'b1;
    wait_n(1);
    we_n = 1'b1;
    wait_n(TC + 1);
    ub_n = 1'b0; lb_n = 1'b0;
    model_wr(i, d, ubm, lbm);
  endtask

  // R2 R4 R11: random access to column 0 then page accesses to columns 1..3
  task automatic rd_page(input int p);
    addr = addr_of(4*p); we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0; ce_n = 1'b0;
    wait_n(TR);
    chk("R11 early oe no drive", {30'd0, drive}, 32'd0);
    wait_n(1);
    chk("R2 random drive", {30'd0, drive}, 32'd3);
    chk("R2 random data", {16'd0, rdata}, {16'd0, mem_m[4*p]});
    for (int c = 1; c < 4; c++) begin
      addr = addr_of(4*p + c);
      wait_n(TP);
      chk("R4 page not yet valid", {30'd0, drive}, 32'd0);
      wait_n(1);
      chk("R4 page data", {14'd0, drive, rdata}, {14'd0, 2'd3, mem_m[4*p + c]});
    end
    close_row();
  endtask

  // R6 R7 R9: write-enable framed page writes inside an open row
  task automatic wr_page_we(input int p, input logic [15:0] seed);
    addr = addr_of(4*p); we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    wait_n(TR + 1);
    chk("R6 read drive before write", {30'd0, drive}, 32'd3);
    for (int c = 0; c < 4; c++) begin
      logic [15:0] d;
      d = seed ^ 16'(c * 16'h0F0F);
      addr = addr_of(4*p + c); wdata = d; we_n = 1'b0;
      wait_n(1);
      chk("R6 drive stops with we low", {30'd0, drive}, 32'd0);
      we_n = 1'b1;
      model_wr(4*p + c, d, 1'b0, 1'b0);
      wait_n(TP);
      chk("R7 R9 page write result", {14'd0, drive, rdata}, {14'd0, 2'd3, mem_m[4*p + c]});
    end
    close_row();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    wait_n(3);
    chk("R1 reset no drive", {30'd0, drive}, 32'd0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 idle no drive", {30'd0, drive}, 32'd0);
    // R1: stored words are zero after reset
    addr = addr_of(13); oe_n = 1'b0; ce_n = 1'b0;
    wait_n(TR + 1);
    chk("R1 reset word", {14'd0, drive, rdata}, {14'd0, 2'd3, 16'd0});
    close_row();

    // sweep all words with lane mask patterns; sector 2 protected
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      d = 16'(16'hC0DE ^ (16'h1357 * (i + 1)));
      wr_ce(i, d, (i % 4) == 2, (i % 4) == 1);
    end
    for (int p = 0; p < 4; p++) rd_page(p);

    // R8 R11: lane gating on an open row
    addr = addr_of(1); oe_n = 1'b0; ce_n = 1'b0;
    wait_n(TR + 1);
    ub_n = 1'b1; wait_n(1);
    chk("R8 lower lane only", {14'd0, drive, rdata}, {14'd0, 2'b01, 8'h00, mem_m[1][7:0]});
    ub_n = 1'b0; lb_n = 1'b1; wait_n(1);
    chk("R8 upper lane only", {14'd0, drive, rdata}, {14'd0, 2'b10, mem_m[1][15:8], 8'h00});
    ub_n = 1'b1; wait_n(1);
    chk("R11 no lane selected", {30'd0, drive}, 32'd0);
    ub_n = 1'b0; lb_n = 1'b0; oe_n = 1'b1; wait_n(1);
    chk("R11 oe high", {30'd0, drive}, 32'd0);
    oe_n = 1'b0; wait_n(1);
    chk("R11 oe low again", {30'd0, drive}, 32'd3);

    // R10: row change with chip enable held low
    addr = addr_of(5);
    wait_n(TC + TR);
    chk("R10 new row not yet valid", {30'd0, drive}, 32'd0);
    wait_n(1);
    chk("R10 new row data", {14'd0, drive, rdata}, {14'd0, 2'd3, mem_m[5]});

    // R3: chip enable high for a single sample, then low again
    ce_n = 1'b1;
    wait_n(1);
    ce_n = 1'b0; addr = addr_of(6);
    wait_n(TC + TR - 1);
    chk("R3 precharge holds access", {30'd0, drive}, 32'd0);
    wait_n(1);
    chk("R3 access after precharge", {14'd0, drive, rdata}, {14'd0, 2'd3, mem_m[6]});
    close_row();

    // R6 R7 R9: page writes in an unprotected and a protected row
    wr_page_we(0, 16'h3C5A);
    wr_page_we(2, 16'h9E21);

    // R7: write-enable framed write closed by chip enable rising first
    addr = addr_of(12); oe_n = 1'b0; ce_n = 1'b0;
    wait_n(TR + 1);
    wdata = 16'hB00C; we_n = 1'b0;
    wait_n(1);
    ce_n = 1'b1;
    wait_n(1);
    we_n = 1'b1;
    model_wr(12, 16'hB00C, 1'b0, 1'b0);
    wait_n(TC + 1);
    chk("R7 model updated by ce close", {16'd0, mem_m[12]}, 32'h0000B00C);

    // read everything back
    for (int p = 0; p < 4; p++) rd_page(p);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule